// File: doc/BRIEF.md
# Debug Communications Channel Mailbox

This block is a two-way, one-word-deep mailbox between an external debugger and software running on the local processor. The debugger reaches it through a small register window, which a scan-chain front end drives with read and write strobes, a register address and write data. The processor side uses plain read and write strobes with a data bus. Each direction holds a single word. Each word has a full flag that data accesses alone set and clear, so neither side needs a separate acknowledge.

The debugger sees two registers. The data register at address 5 carries words in both directions: a read collects the processor's word and a write delivers a word to the processor. The control register at address 4 reports both handshake flags in its low bits and a fixed hardware version number in its top nibble. A debugger probes that nibble to learn what the hardware can do. If the processor writes a word that the debugger has not yet collected, the old word is replaced and a sticky overflow flag is raised.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset both handshake flags and the overflow flag are 0, and the control register reads VERSION in bits 31:28 with every other bit 0 (default VERSION is 6).
- R2: The control register is at address 4. Bit 0 is the processor-bound full flag (R), bit 1 is the debugger-bound full flag (W), bits 27:2 read as zero and bits 31:28 hold VERSION. The data register is at address 5.
- R3: A processor write stores the word and sets W (control bit 1) on the next cycle. While the address is 5, the debugger read data shows that word.
- R4: A debugger read strobe at address 5 collects the word and clears W on the next cycle.
- R5: A debugger read of the control register (address 4) changes neither flag nor either stored word.
- R6: A debugger write at address 5 stores the word, which then appears on cpu_rdata, and sets R (control bit 0) on the next cycle.
- R7: A processor read strobe clears R on the next cycle.
- R8: A processor write while W is 1, with no debugger collection in the same cycle, replaces the word and sets the overflow flag. The overflow flag stays 1 until reset.
- R9: The following have no effect on flags or words: debugger writes to address 4 or to any address other than 5, processor reads while R is 0, and debugger data reads while W is 0. Reads at addresses other than 4 and 5 return zero.
- R10: When a write and a collection of the same direction fall in the same cycle, the reader gets the old word, the new word is stored, the flag stays 1 and the overflow flag is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_rd | input | 1 | Debugger register read strobe |
| dbg_wr | input | 1 | Debugger register write strobe |
| dbg_addr | input | ADDR_W | Debugger register address |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data for dbg_addr (combinational) |
| cpu_rd | input | 1 | Processor read strobe, consumes the inbound word |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Word last delivered by the debugger |
| cpu_rx_full | output | 1 | R flag: an inbound word waits for the processor |
| cpu_tx_full | output | 1 | W flag: an outbound word waits for the debugger |
| ovf | output | 1 | Sticky overflow of the outbound word |

## Verification
The bench checks that a control register read leaves both flags untouched; a design that decoded any read as a collection would clear W there. It checks same-cycle write and collection on the outbound word; a design that let the clear win would drop W and lose a word, and one that flagged overflow there would raise a false error. Strobes aimed at the wrong address or at an empty slot are also checked. A loose decoder or a flag that toggled instead of being set and cleared would corrupt state in those cases. Overflow persistence is also tested, because a flag that followed W would clear itself once the debugger collected the word.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int WORD_W   = 32;
  localparam int VER_W    = 4;
  localparam int FLAG_LSB = 0;

  // Control word: version in the top nibble, flags in bits 1:0, rest zero.
  function automatic logic [WORD_W-1:0] pack_ctrl(input logic [VER_W-1:0] ver,
                                                  input logic rx_full,
                                                  input logic tx_full);
    logic [WORD_W-1:0] v;
    v = '0;
    v[WORD_W-1 -: VER_W] = ver;
    v[FLAG_LSB]          = rx_full;
    v[FLAG_LSB+1]        = tx_full;
    return v;
  endfunction

  // Next value of a full flag: a write wins over a read in the same cycle.
  function automatic logic next_full(input logic cur, input logic wr, input logic rd);
    return wr ? 1'b1 : (rd ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] word,
  output logic         full
);
  import dcc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      full <= 1'b0;
    end else begin
      if (wr_en) word <= wr_data;
      full <= next_full(full, wr_en, rd_en);
    end
  end

  // R3 R6
  slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full);
  // R4 R7
  slot_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> !full);
  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(word));
  // R9
  slot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> $stable(full));
endmodule

// File: rtl/dcc_dbg_decode.sv
module dcc_dbg_decode #(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 4,
  parameter int DATA_ADDR = 5
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_sel,
  output logic              data_sel,
  output logic              data_rd,
  output logic              data_wr
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  always_comb begin
    ctrl_sel = (addr == CTRL_A);
    data_sel = (addr == DATA_A);
    data_rd  = rd && data_sel;
    data_wr  = wr && data_sel;
  end
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox #(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 4,
  parameter int DATA_ADDR = 5,
  parameter int VERSION   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dbg_rd,
  input  logic                       dbg_wr,
  input  logic [ADDR_W-1:0]          dbg_addr,
  input  logic [dcc_pkg::WORD_W-1:0] dbg_wdata,
  output logic [dcc_pkg::WORD_W-1:0] dbg_rdata,
  input  logic                       cpu_rd,
  input  logic                       cpu_wr,
  input  logic [dcc_pkg::WORD_W-1:0] cpu_wdata,
  output logic [dcc_pkg::WORD_W-1:0] cpu_rdata,
  output logic                       cpu_rx_full,
  output logic                       cpu_tx_full,
  output logic                       ovf
);
  import dcc_pkg::*;

  localparam logic [VER_W-1:0] VER = VER_W'(VERSION);

  logic              ctrl_sel, data_sel, collect, deliver;
  logic [WORD_W-1:0] up_word;
  logic              overwrite_evt;
  logic              ovf_q;

  dcc_dbg_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .rd(dbg_rd), .wr(dbg_wr), .addr(dbg_addr),
    .ctrl_sel(ctrl_sel), .data_sel(data_sel),
    .data_rd(collect), .data_wr(deliver)
  );

  // Debugger to processor.
  dcc_slot #(.W(WORD_W)) u_down (
    .clk(clk), .rst_n(rst_n),
    .wr_en(deliver), .wr_data(dbg_wdata),
    .rd_en(cpu_rd),
    .word(cpu_rdata), .full(cpu_rx_full)
  );

  // Processor to debugger.
  dcc_slot #(.W(WORD_W)) u_up (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cpu_wr), .wr_data(cpu_wdata),
    .rd_en(collect),
    .word(up_word), .full(cpu_tx_full)
  );

  assign overwrite_evt = cpu_wr && cpu_tx_full && !collect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if (overwrite_evt) ovf_q <= 1'b1;
  end
  assign ovf = ovf_q;

  always_comb begin
    if (data_sel)      dbg_rdata = up_word;
    else if (ctrl_sel) dbg_rdata = pack_ctrl(VER, cpu_rx_full, cpu_tx_full);
    else               dbg_rdata = '0;
  end

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_tx_full && !(dbg_rd && data_sel)) |=> ovf);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R5
  ctrl_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd && !dbg_wr && ctrl_sel && !cpu_rd && !cpu_wr)
      |=> ($stable(cpu_rx_full) && $stable(cpu_tx_full) && $stable(cpu_rdata)));
  // R10
  same_cycle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && dbg_rd && data_sel) |=> (cpu_tx_full && $stable(ovf)));
endmodule

// File: tb/dcc_mailbox_test.sv
`timescale 1ns/1ps
module dcc_mailbox_test;
  localparam int VER = 6;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_rd = 1'b0, dbg_wr = 1'b0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic        cpu_rx_full, cpu_tx_full, ovf;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dcc_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .dbg_rd(dbg_rd), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rx_full(cpu_rx_full),
    .cpu_tx_full(cpu_tx_full), .ovf(ovf)
  );

  function automatic logic [31:0] exp_ctrl(input logic w, input logic r);
    return (32'(VER) << 28) | {30'd0, w, r};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    dbg_addr = a;
    #1 v = dbg_rdata;
  endtask

  task automatic dbg_access(input logic rd, input logic wr, input logic [4:0] a,
                            input logic [31:0] d, output logic [31:0] v);
    @(negedge clk);
    dbg_rd = rd; dbg_wr = wr; dbg_addr = a; dbg_wdata = d;
    #1 v = dbg_rdata;
    @(negedge clk);
    dbg_rd = 1'b0; dbg_wr = 1'b0;
  endtask

  task automatic cpu_access(input logic rd, input logic wr, input logic [31:0] d);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    peek(5'd4, v);
    check("R1 ctrl after reset", v, exp_ctrl(1'b0, 1'b0));
    check("R1 flags after reset", {29'd0, ovf, cpu_tx_full, cpu_rx_full}, 32'd0);
  endtask

  task automatic t_cpu_to_dbg();
    logic [31:0] v;
    cpu_access(1'b0, 1'b1, 32'hA5A5_1234);
    peek(5'd4, v);
    check("R2 R3 W set in ctrl bit1", v, exp_ctrl(1'b1, 1'b0));
    dbg_access(1'b1, 1'b0, 5'd5, 32'd0, v);
    check("R3 debugger data", v, 32'hA5A5_1234);
    peek(5'd4, v);
    check("R4 W cleared by collect", v, exp_ctrl(1'b0, 1'b0));
  endtask

  task automatic t_dbg_to_cpu();
    logic [31:0] v;
    dbg_access(1'b0, 1'b1, 5'd5, 32'h0BAD_F00D, v);
    check("R6 cpu_rdata", cpu_rdata, 32'h0BAD_F00D);
    peek(5'd4, v);
    check("R2 R6 R set in ctrl bit0", v, exp_ctrl(1'b0, 1'b1));
    // R5: control read must leave R and the word as they are
    dbg_access(1'b1, 1'b0, 5'd4, 32'd0, v);
    check("R5 ctrl read value", v, exp_ctrl(1'b0, 1'b1));
    check("R5 R kept after ctrl read", {31'd0, cpu_rx_full}, 32'd1);
    cpu_access(1'b1, 1'b0, 32'd0);
    check("R7 R cleared by cpu read", {31'd0, cpu_rx_full}, 32'd0);
    check("R7 word kept", cpu_rdata, 32'h0BAD_F00D);
  endtask

  task automatic t_ctrl_quiet_w();
    logic [31:0] v;
    cpu_access(1'b0, 1'b1, 32'h1111_2222);
    dbg_access(1'b1, 1'b0, 5'd4, 32'd0, v);
    check("R5 W kept after ctrl read", {31'd0, cpu_tx_full}, 32'd1);
    dbg_access(1'b1, 1'b0, 5'd5, 32'd0, v);
    check("R5 word intact", v, 32'h1111_2222);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    dbg_access(1'b0, 1'b1, 5'd4, 32'hFFFF_FFFF, v);
    peek(5'd4, v);
    check("R9 write to ctrl ignored", v, exp_ctrl(1'b0, 1'b0));
    dbg_access(1'b0, 1'b1, 5'd7, 32'h7777_7777, v);
    check("R9 write to addr7 word", cpu_rdata, 32'h0BAD_F00D);
    check("R9 write to addr7 R", {31'd0, cpu_rx_full}, 32'd0);
    peek(5'd7, v);
    check("R9 addr7 reads zero", v, 32'd0);
    cpu_access(1'b1, 1'b0, 32'd0);
    check("R9 cpu read while empty", {31'd0, cpu_rx_full}, 32'd0);
    dbg_access(1'b1, 1'b0, 5'd5, 32'd0, v);
    peek(5'd4, v);
    check("R9 collect while empty", v, exp_ctrl(1'b0, 1'b0));
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    cpu_access(1'b0, 1'b1, 32'hCAFE_0001);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = 32'hCAFE_0002;
    dbg_rd = 1'b1; dbg_addr = 5'd5;
    #1 v = dbg_rdata;
    check("R10 reader gets old word", v, 32'hCAFE_0001);
    @(negedge clk);
    cpu_wr = 1'b0; dbg_rd = 1'b0;
    check("R10 W stays set", {31'd0, cpu_tx_full}, 32'd1);
    check("R10 no overflow", {31'd0, ovf}, 32'd0);
    dbg_access(1'b1, 1'b0, 5'd5, 32'd0, v);
    check("R10 new word stored", v, 32'hCAFE_0002);
    // inbound direction: deliver and consume together
    @(negedge clk);
    dbg_wr = 1'b1; dbg_addr = 5'd5; dbg_wdata = 32'h5555_AAAA;
    @(negedge clk);
    dbg_wr = 1'b0;
    @(negedge clk);
    dbg_wr = 1'b1; dbg_wdata = 32'h6666_BBBB; cpu_rd = 1'b1;
    @(negedge clk);
    dbg_wr = 1'b0; cpu_rd = 1'b0;
    check("R10 R stays set", {31'd0, cpu_rx_full}, 32'd1);
    check("R10 new inbound word", cpu_rdata, 32'h6666_BBBB);
    cpu_access(1'b1, 1'b0, 32'd0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    cpu_access(1'b0, 1'b1, 32'hDEAD_0001);
    check("R8 no ovf on first write", {31'd0, ovf}, 32'd0);
    cpu_access(1'b0, 1'b1, 32'hDEAD_0002);
    check("R8 ovf raised", {31'd0, ovf}, 32'd1);
    dbg_access(1'b1, 1'b0, 5'd5, 32'd0, v);
    check("R8 word overwritten", v, 32'hDEAD_0002);
    repeat (3) @(negedge clk);
    check("R8 ovf sticky", {31'd0, ovf}, 32'd1);
    check("R8 W cleared", {31'd0, cpu_tx_full}, 32'd0);
    do_reset();
    check("R1 ovf cleared by reset", {31'd0, ovf}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_cpu_to_dbg();
    t_dbg_to_cpu();
    t_ctrl_quiet_w();
    t_ignored();
    t_same_cycle();
    t_overflow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule